// File: doc/BRIEF.md
# Parallel Port Side with Edge Interrupt Flag

This block implements one half of a memory-mapped parallel peripheral. A CPU reaches it through a small register window: two select lines, a chip select, separate read and write strobes, and an 8-bit data bus. On the device side it drives eight port pins, each with its own output enable, and it samples the pin levels back. It also watches one asynchronous trigger line for a chosen edge.

When the selected edge occurs, the block latches a status flag. Software can enable the flag onto an active-low interrupt request. The flag is acknowledged by reading the port data, not by reading the control register. The direction register and the output data register share one address, and a control bit picks which one that address reaches.

The CPU bus is a plain register interface and not a stream. Every access completes in the cycle its strobe is high, so there is no valid/ready handshake and no back-pressure. A write takes effect at the clock edge that ends the strobe cycle. Read data is combinational while `cs` and `rd_stb` are both high, and is zero otherwise.

Top module: `pport_side`

## Requirements
- R1: After reset the direction, output and control registers and the flag are all zero. `pin_oe` is 0x00, `pin_out` is 0x00 and `irq_n` is 1.
- R2: With `sel` = 2'b11 the access reaches the control register. A write stores `wdata[5:0]`. A read returns {flag, 1'b0, control[5:0]}.
- R3: With `sel` = 2'b10 and control bit 2 = 0, the access reaches the direction register, and `pin_oe` equals that register (1 = output).
- R4: With `sel` = 2'b10 and control bit 2 = 1, a write stores the output data register, and `pin_out` equals that register.
- R5: A read with `sel` = 2'b10 and control bit 2 = 1 returns (out & dir) | (pin_in & ~dir).
- R6: Read-data bits 7 and 6 of the control register are status bits. A control write never changes them, and bit 6 always reads 0.
- R7: Control bit 1 selects the active edge of `trig_in` (0 = falling, 1 = rising). An active edge sets the flag, and the flag is visible three clock edges after `trig_in` changes. The opposite edge has no effect.
- R8: A read of the output data register (`sel` = 2'b10, control bit 2 = 1) clears the flag. A read of the control register or of the direction register leaves it unchanged.
- R9: If a flag-clearing read and a detected active edge fall in the same cycle, the flag ends up set.
- R10: The flag is set whatever the value of control bit 0. `irq_n` is 0 exactly while the flag and control bit 0 are both 1.
- R11: Accesses with `sel` = 2'b00 or 2'b01 read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select |
| sel | input | 2 | Register select |
| rd_stb | input | 1 | Read strobe |
| wr_stb | input | 1 | Write strobe |
| wdata | input | 8 | CPU write data |
| rdata | output | 8 | CPU read data |
| pin_in | input | 8 | Sampled pin levels |
| pin_out | output | 8 | Output data for the pins |
| pin_oe | output | 8 | Per-pin output enable |
| trig_in | input | 1 | Asynchronous interrupt trigger line |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The hardest case to reach is a flag-clearing data read that lands in the exact cycle the edge detector fires. From the ports, that cycle sits two clock edges after `trig_in` moves. The stimulus changes `trig_in` at a falling clock edge, counts two rising edges, and only then raises the read strobe for one cycle. It then checks that the flag survived. Edge polarity is exercised in both modes with the opposite edge applied first, and the interrupt enable is toggled while the flag is set. Random register traffic against a bench model covers the address sharing and the pin read mix.

// File: rtl/pport_pkg.sv
package pport_pkg;
  localparam logic [1:0] SEL_PORT = 2'b10;
  localparam logic [1:0] SEL_CTRL = 2'b11;
  localparam int CTRL_W   = 6;
  localparam int B_IRQEN  = 0;
  localparam int B_RISE   = 1;
  localparam int B_DATSEL = 2;
endpackage

// File: rtl/pport_edge.sv
module pport_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  input  logic rise_sel,
  output logic hit
);
  logic [STAGES-1:0] chain;
  logic              last;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= async_in;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], async_in};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) last <= 1'b0;
    else        last <= chain[STAGES-1];

  always_comb
    hit = rise_sel ? (chain[STAGES-1] & ~last) : (~chain[STAGES-1] & last);
endmodule

// File: rtl/pport_regs.sv
module pport_regs
  import pport_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_dir,
  input  logic              wr_out,
  input  logic              rd_clr,
  input  logic [DW-1:0]     wdata,
  input  logic              edge_hit,
  output logic [DW-1:0]     dir_q,
  output logic [DW-1:0]     out_q,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              flag_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      out_q  <= '0;
      ctrl_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata[CTRL_W-1:0];
      if (wr_dir)  dir_q  <= wdata;
      if (wr_out)  out_q  <= wdata;
    end
  end

  // a detected edge takes priority over the acknowledge read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (edge_hit) flag_q <= 1'b1;
    else if (rd_clr)   flag_q <= 1'b0;
  end
endmodule

// File: rtl/pport_rmux.sv
module pport_rmux
  import pport_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              rd_en,
  input  logic [1:0]        sel,
  input  logic [CTRL_W-1:0] ctrl_q,
  input  logic              flag_q,
  input  logic [DW-1:0]     dir_q,
  input  logic [DW-1:0]     out_q,
  input  logic [DW-1:0]     pin_in,
  output logic [DW-1:0]     rdata
);
  logic [DW-1:0] mixed;

  always_comb begin
    mixed = (out_q & dir_q) | (pin_in & ~dir_q);
    rdata = '0;
    if (rd_en) begin
      case (sel)
        SEL_CTRL: begin
          rdata[CTRL_W-1:0] = ctrl_q;
          rdata[DW-1]       = flag_q;
        end
        SEL_PORT: rdata = ctrl_q[B_DATSEL] ? mixed : dir_q;
        default:  rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/pport_side.sv
module pport_side
  import pport_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic [1:0]    sel,
  input  logic          rd_stb,
  input  logic          wr_stb,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] pin_in,
  output logic [DW-1:0] pin_out,
  output logic [DW-1:0] pin_oe,
  input  logic          trig_in,
  output logic          irq_n
);
  logic [DW-1:0]     dir_q, out_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic              flag_q, edge_hit;
  logic              wr_en, rd_en, at_port, at_ctrl;
  logic              wr_ctrl, wr_dir, wr_out, rd_clr;

  always_comb begin
    wr_en   = cs & wr_stb;
    rd_en   = cs & rd_stb;
    at_port = (sel == SEL_PORT);
    at_ctrl = (sel == SEL_CTRL);
    wr_ctrl = wr_en & at_ctrl;
    wr_dir  = wr_en & at_port & ~ctrl_q[B_DATSEL];
    wr_out  = wr_en & at_port &  ctrl_q[B_DATSEL];
    rd_clr  = rd_en & at_port &  ctrl_q[B_DATSEL];
  end

  pport_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (trig_in),
    .rise_sel (ctrl_q[B_RISE]),
    .hit      (edge_hit)
  );

  pport_regs #(.DW(DW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_ctrl  (wr_ctrl),
    .wr_dir   (wr_dir),
    .wr_out   (wr_out),
    .rd_clr   (rd_clr),
    .wdata    (wdata),
    .edge_hit (edge_hit),
    .dir_q    (dir_q),
    .out_q    (out_q),
    .ctrl_q   (ctrl_q),
    .flag_q   (flag_q)
  );

  pport_rmux #(.DW(DW)) u_rmux (
    .rd_en  (rd_en),
    .sel    (sel),
    .ctrl_q (ctrl_q),
    .flag_q (flag_q),
    .dir_q  (dir_q),
    .out_q  (out_q),
    .pin_in (pin_in),
    .rdata  (rdata)
  );

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
  assign irq_n   = ~(flag_q & ctrl_q[B_IRQEN]);
endmodule

// File: rtl/pport_side_chk.sv
module pport_side_chk
  import pport_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cs,
  input logic [1:0]        sel,
  input logic              rd_stb,
  input logic              wr_stb,
  input logic              irq_n,
  input logic              edge_hit,
  input logic              flag_q,
  input logic [CTRL_W-1:0] ctrl_q
);
  logic ctrl_wr, ctrl_rd, dat_rd;
  assign ctrl_wr = cs & wr_stb & (sel == SEL_CTRL);
  assign ctrl_rd = cs & rd_stb & (sel == SEL_CTRL);
  assign dat_rd  = cs & rd_stb & (sel == SEL_PORT) & ctrl_q[B_DATSEL];

  p_edge_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    edge_hit |=> flag_q);
  p_clear_on_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_rd && !edge_hit) |=> !flag_q);
  p_ctrl_read_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rd && !edge_hit) |=> $stable(flag_q));
  p_ctrl_write_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !edge_hit) |=> $stable(flag_q));
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_rd && edge_hit) |=> flag_q);
  p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (flag_q && ctrl_q[B_IRQEN]));
endmodule

bind pport_side pport_side_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs       (cs),
  .sel      (sel),
  .rd_stb   (rd_stb),
  .wr_stb   (wr_stb),
  .irq_n    (irq_n),
  .edge_hit (edge_hit),
  .flag_q   (flag_q),
  .ctrl_q   (ctrl_q)
);

// File: tb/pport_side_bench.sv
`timescale 1ns/1ps
module pport_side_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, rd_stb = 1'b0, wr_stb = 1'b0;
  logic [1:0] sel = 2'b00;
  logic [7:0] wdata = 8'h00, pin_in = 8'h00;
  logic [7:0] rdata, pin_out, pin_oe;
  logic       trig_in = 1'b0;
  logic       irq_n;

  int n_chk = 0, n_bad = 0;
  logic [7:0] m_dir = 8'h00, m_out = 8'h00;
  logic [5:0] m_ctrl = 6'h00;
  logic       m_flag = 1'b0;

  always #10 clk = ~clk;

  pport_side u_pport_side (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sel(sel), .rd_stb(rd_stb),
    .wr_stb(wr_stb), .wdata(wdata), .rdata(rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .trig_in(trig_in), .irq_n(irq_n)
  );

  function automatic logic [7:0] exp_read(input logic [1:0] s);
    if (s == 2'b11) return {m_flag, 1'b0, m_ctrl};
    if (s == 2'b10) return m_ctrl[2] ? ((m_out & m_dir) | (pin_in & ~m_dir)) : m_dir;
    return 8'h00;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; wr_stb = 1'b1; sel = s; wdata = d;
    @(negedge clk);
    cs = 1'b0; wr_stb = 1'b0;
    if (s == 2'b11) m_ctrl = d[5:0];
    else if (s == 2'b10) begin
      if (m_ctrl[2]) m_out = d; else m_dir = d;
    end
  endtask

  task automatic do_read(input string req, input logic [1:0] s);
    logic [7:0] e;
    @(negedge clk);
    cs = 1'b1; rd_stb = 1'b1; sel = s;
    #1;
    e = exp_read(s);
    check(req, rdata, e);
    @(negedge clk);
    cs = 1'b0; rd_stb = 1'b0;
    if (s == 2'b10 && m_ctrl[2]) m_flag = 1'b0;
  endtask

  task automatic move_trig(input logic v);
    @(negedge clk);
    trig_in = v;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h01, 8'h00);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 oe", pin_oe, 8'h00);
    check("R1 out", pin_out, 8'h00);
    check("R1 irq", {7'd0, irq_n}, 8'h01);
    do_read("R1 ctrl", 2'b11);

    // R2 / R6 control register
    do_write(2'b11, 8'h3B);
    do_read("R2 ctrl readback", 2'b11);
    do_write(2'b11, 8'hC0);
    do_read("R6 status bits", 2'b11);

    // R3 direction, R4 output data, R5 mixed read
    do_write(2'b10, 8'hF0);
    check("R3 oe", pin_oe, 8'hF0);
    do_read("R3 dir read", 2'b10);
    do_write(2'b11, 8'h04);
    do_write(2'b10, 8'hA5);
    check("R4 out", pin_out, 8'hA5);
    check("R3 dir kept", pin_oe, 8'hF0);
    pin_in = 8'h3C;
    do_read("R5 mixed", 2'b10);
    check("R5 value", 8'hAC, exp_read(2'b10));

    // R11 unused addresses
    do_write(2'b01, 8'hFF);
    do_write(2'b00, 8'h55);
    do_read("R11 read01", 2'b01);
    do_read("R11 ctrl kept", 2'b11);
    check("R11 oe kept", pin_oe, 8'hF0);

    // R7 falling mode: rising edge ignored, falling edge sets
    move_trig(1'b1);
    do_read("R7 opposite edge", 2'b11);
    move_trig(1'b0);
    m_flag = 1'b1;
    check("R10 irq disabled", {7'd0, irq_n}, 8'h01);
    do_read("R7 falling set", 2'b11);
    do_read("R8 ctrl read keeps", 2'b11);
    do_write(2'b11, 8'h05);
    check("R10 irq enabled", {7'd0, irq_n}, 8'h00);
    do_read("R8 data read", 2'b10);
    check("R8 irq after clear", {7'd0, irq_n}, 8'h01);
    do_read("R8 flag cleared", 2'b11);

    // R8 direction read leaves flag
    do_write(2'b11, 8'h03);
    move_trig(1'b1);
    m_flag = 1'b1;
    check("R7 rising irq", {7'd0, irq_n}, 8'h00);
    do_read("R8 dir read keeps", 2'b10);
    do_read("R8 flag still set", 2'b11);
    do_write(2'b11, 8'h07);
    do_read("R8 clear rising", 2'b10);
    move_trig(1'b0);
    do_read("R7 falling ignored", 2'b11);

    // R9 clear read coinciding with detection
    @(negedge clk);
    trig_in = 1'b1;
    repeat (2) @(negedge clk);
    cs = 1'b1; rd_stb = 1'b1; sel = 2'b10;
    @(negedge clk);
    cs = 1'b0; rd_stb = 1'b0;
    m_flag = 1'b1;
    do_read("R9 set wins", 2'b11);

    // random register traffic, trigger held still
    for (int i = 0; i < 300; i++) begin
      logic [1:0] s;
      s = 2'($urandom_range(0, 3));
      pin_in = 8'($urandom);
      if ($urandom_range(0, 1) == 0) do_write(s, 8'($urandom));
      else do_read("R5 R2 R11 random", s);
      check("R3 R4 random pins", pin_oe ^ pin_out, m_dir ^ m_out);
      check("R10 random irq", {7'd0, irq_n}, {7'd0, ~(m_flag & m_ctrl[0])});
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule